// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array

This block models a write-once storage array built from equal fuse banks, each made of 32-bit rows. Bits start out blank (zero) after reset and can only be set by a program request. A program request names a flat bit index. It is taken with a valid/ready handshake and answered one cycle later with an accept or a reject pulse. A request is rejected when the index is beyond the array or appears in a parameterised table of protected indices. Whole rows and single bits are read combinationally.

Each bank reserves the top nibble of its first row as a factory marker. A marker scan, started by a pulse, visits one bank per cycle from the highest bank down to bank 0. It returns a pass vector with one bit per bank. It can optionally stamp the correct marker into banks whose field is still blank. While a scan runs, program requests are held off. A debug row write port, enabled only by its own strobe, lets a test environment preload contents.

Top module: `otp_fuse_array`

## Requirements
- R1: An accepted program request for index i sets bit (i mod 32) of row (i div 32). The change is visible on the row and bit read ports in the cycle after acceptance.
- R2: No program request ever clears a bit. Programming a bit that is already set is accepted and leaves every row unchanged.
- R3: A request whose index matches a table entry whose valid-mask bit is 1 is answered with a reject pulse and leaves the array unchanged. Entries whose valid-mask bit is 0 protect nothing.
- R4: A request whose index is at or beyond NUM_BANKS*BANK_BITS is rejected and changes nothing.
- R5: Each accepted handshake (valid and ready high at a clock edge) gives exactly one pulse, accept or reject, in the following cycle, and never both. Ready is low for the whole of a marker scan.
- R6: After reset every row reads zero, ready is high, and the accept, reject, busy and done outputs are low.
- R7: Bank n's marker is bits 31:28 of row n*BANK_BITS/32. The bank passes only when that field equals 4'b1010.
- R8: With auto-fill requested, a bank whose marker field is 4'b0000 gets 4'b1010 written into it and passes. The other bits of that row are kept. A nonzero wrong marker is never corrected and fails. With auto-fill off, a blank marker fails and stays blank.
- R9: The pass vector holds bank n in bit n. Done pulses for one cycle exactly NUM_BANKS cycles after the start pulse is taken, with busy high in between.
- R10: The debug port replaces a whole row only when its enable is high. With the enable low, its data and row inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, blanks the array |
| pg_valid | input | 1 | Program request valid |
| pg_idx | input | IDX_W | Flat bit index to program |
| pg_ready | output | 1 | Program port can take a request |
| pg_ack | output | 1 | One-cycle pulse: request applied |
| pg_nak | output | 1 | One-cycle pulse: request refused |
| rd_row | input | ROW_AW | Row read address |
| rd_row_data | output | 32 | Row contents (zero when out of range) |
| rd_bit_idx | input | IDX_W | Single-bit read index |
| rd_bit | output | 1 | Selected bit (zero when out of range) |
| chk_start | input | 1 | Start a marker scan |
| chk_autofill | input | 1 | Stamp blank markers during this scan |
| chk_busy | output | 1 | Scan in progress |
| chk_done | output | 1 | One-cycle pulse at scan end |
| chk_pass | output | NUM_BANKS | Per-bank marker result, bank n in bit n |
| dbg_en | input | 1 | Debug row write enable |
| dbg_row | input | ROW_AW | Debug row address |
| dbg_data | input | 32 | Debug row data |

## Verification
The bench programs a protected index, an index that matches a table entry with a cleared valid bit, the last legal index and indices just past the array. Each of these shows up as a wrong pulse or a changed row if the comparison, the valid mask or the range test is broken. Long random program runs against a model catch a design that writes the wrong row or bit, or one that clears bits. Marker scans cover a blank, a correct and a wrong marker, with auto-fill on and off. Each scan also uses a pattern where only the top bank passes. A reversed vector, a corrected wrong marker, a fill that clobbers the row's low bits, or a wrong scan length would each show up there.

// File: rtl/otp_pkg.sv
package otp_pkg;
   localparam int unsigned ROW_W   = 32;
   localparam int unsigned MARK_HI = 31;
   localparam int unsigned MARK_LO = 28;
   localparam logic [3:0]  MARK_OK = 4'b1010;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_st_e;
endpackage

// File: rtl/otp_prot_match.sv
module otp_prot_match #(
   parameter int unsigned IDX_W      = 13,
   parameter int unsigned PROT_N     = 4,
   parameter logic [PROT_N*32-1:0] PROT_IDX   = '0,
   parameter logic [PROT_N-1:0]    PROT_VALID = '0
) (
   input  logic [IDX_W-1:0] idx,
   output logic             hit
);
   logic [PROT_N-1:0] lane_hit;
   logic [31:0]       idx_ext;

   assign idx_ext = 32'(idx);

   for (genvar i = 0; i < PROT_N; i++) begin : g_lane
      if (PROT_VALID[i]) begin : g_live
         assign lane_hit[i] = (idx_ext == PROT_IDX[i*32 +: 32]);
      end else begin : g_dead
         assign lane_hit[i] = 1'b0;
      end
   end

   assign hit = |lane_hit;
endmodule

// File: rtl/otp_mark_scan.sv
module otp_mark_scan
   import otp_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 3,
   parameter int unsigned BANK_ROWS    = 64,
   parameter int unsigned ROW_AW       = 8,
   parameter bit          HAS_AUTOFILL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 autofill,
   input  logic [ROW_W-1:0]     row_data,
   output logic [ROW_AW-1:0]    row_addr,
   output logic                 fill_en,
   output logic                 busy,
   output logic                 done,
   output logic [NUM_BANKS-1:0] pass
);
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NUM_BANKS - 1);

   scan_st_e             st_q;
   logic [BANK_W-1:0]    ptr_q;
   logic [NUM_BANKS-1:0] acc_q;
   logic [3:0]           field;
   logic                 fill_ok;
   logic                 bank_ok;

   assign row_addr = ROW_AW'(int'(ptr_q) * BANK_ROWS);
   assign field    = row_data[MARK_HI:MARK_LO];
   assign busy     = (st_q == SCAN_RUN);

   if (HAS_AUTOFILL) begin : g_fill
      logic auto_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            auto_q <= 1'b0;
         end else if (start && !busy) begin
            auto_q <= autofill;
         end
      end
      assign fill_ok = auto_q;
   end else begin : g_nofill
      assign fill_ok = 1'b0;
   end

   assign fill_en = busy && fill_ok && (field == 4'b0000);
   assign bank_ok = (field == MARK_OK) || fill_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SCAN_IDLE;
         ptr_q <= '0;
         acc_q <= '0;
         pass  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            SCAN_IDLE: begin
               if (start) begin
                  st_q  <= SCAN_RUN;
                  ptr_q <= TOP_BANK;
                  acc_q <= '0;
               end
            end
            SCAN_RUN: begin
               acc_q <= NUM_BANKS'({acc_q, bank_ok});
               if (ptr_q == '0) begin
                  st_q <= SCAN_IDLE;
                  pass <= NUM_BANKS'({acc_q, bank_ok});
                  done <= 1'b1;
               end else begin
                  ptr_q <= ptr_q - 1'b1;
               end
            end
            default: st_q <= SCAN_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
   import otp_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 3,
   parameter int unsigned BANK_BITS    = 2048,
   parameter int unsigned PROT_N       = 4,
   parameter logic [PROT_N*32-1:0] PROT_IDX =
      {32'd6143, 32'd2079, 32'd100, 32'd5},
   parameter logic [PROT_N-1:0] PROT_VALID = 4'b1011,
   parameter bit          HAS_AUTOFILL = 1'b1,
   localparam int unsigned BANK_ROWS  = BANK_BITS / 32,
   localparam int unsigned TOTAL_ROWS = NUM_BANKS * BANK_ROWS,
   localparam int unsigned ROW_AW     = $clog2(TOTAL_ROWS),
   localparam int unsigned IDX_W      = ROW_AW + 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pg_valid,
   input  logic [IDX_W-1:0]     pg_idx,
   output logic                 pg_ready,
   output logic                 pg_ack,
   output logic                 pg_nak,
   input  logic [ROW_AW-1:0]    rd_row,
   output logic [31:0]          rd_row_data,
   input  logic [IDX_W-1:0]     rd_bit_idx,
   output logic                 rd_bit,
   input  logic                 chk_start,
   input  logic                 chk_autofill,
   output logic                 chk_busy,
   output logic                 chk_done,
   output logic [NUM_BANKS-1:0] chk_pass,
   input  logic                 dbg_en,
   input  logic [ROW_AW-1:0]    dbg_row,
   input  logic [31:0]          dbg_data
);
   if (BANK_BITS == 0 || (BANK_BITS % 32) != 0) begin : g_bad_bank
      $error("BANK_BITS must be a nonzero multiple of 32");
   end
   if (NUM_BANKS < 1) begin : g_bad_num
      $error("NUM_BANKS must be at least 1");
   end
   if (PROT_N < 1) begin : g_bad_prot
      $error("PROT_N must be at least 1");
   end

   logic [ROW_W-1:0]  fuse [TOTAL_ROWS];
   logic              pg_fire;
   logic              prot_hit;
   logic              pg_in_range;
   logic [ROW_AW-1:0] pg_row;
   logic [4:0]        pg_bit;
   logic [ROW_AW-1:0] rb_row;
   logic [ROW_AW-1:0] scan_row;
   logic [ROW_W-1:0]  scan_data;
   logic              scan_fill;

   assign pg_row      = pg_idx[IDX_W-1:5];
   assign pg_bit      = pg_idx[4:0];
   assign pg_in_range = (int'(pg_row) < TOTAL_ROWS);
   assign pg_ready    = !chk_busy;
   assign pg_fire     = pg_valid && pg_ready;

   otp_prot_match #(
      .IDX_W     (IDX_W),
      .PROT_N    (PROT_N),
      .PROT_IDX  (PROT_IDX),
      .PROT_VALID(PROT_VALID)
   ) u_prot (
      .idx(pg_idx),
      .hit(prot_hit)
   );

   otp_mark_scan #(
      .NUM_BANKS   (NUM_BANKS),
      .BANK_ROWS   (BANK_ROWS),
      .ROW_AW      (ROW_AW),
      .HAS_AUTOFILL(HAS_AUTOFILL)
   ) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (chk_start),
      .autofill(chk_autofill),
      .row_data(scan_data),
      .row_addr(scan_row),
      .fill_en (scan_fill),
      .busy    (chk_busy),
      .done    (chk_done),
      .pass    (chk_pass)
   );

   assign scan_data = fuse[scan_row];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < TOTAL_ROWS; r++) fuse[r] <= '0;
         pg_ack <= 1'b0;
         pg_nak <= 1'b0;
      end else begin
         pg_ack <= pg_fire && pg_in_range && !prot_hit;
         pg_nak <= pg_fire && !(pg_in_range && !prot_hit);
         if (dbg_en && int'(dbg_row) < TOTAL_ROWS) begin
            fuse[dbg_row] <= dbg_data;
         end
         if (pg_fire && pg_in_range && !prot_hit) begin
            fuse[pg_row][pg_bit] <= 1'b1;
         end
         if (scan_fill) begin
            fuse[scan_row][MARK_HI:MARK_LO] <= MARK_OK;
         end
      end
   end

   assign rd_row_data = (int'(rd_row) < TOTAL_ROWS) ? fuse[rd_row] : '0;
   assign rb_row      = rd_bit_idx[IDX_W-1:5];
   assign rd_bit      = (int'(rb_row) < TOTAL_ROWS) ? fuse[rb_row][rd_bit_idx[4:0]] : 1'b0;
endmodule

// File: rtl/otp_fuse_array_chk.sv
module otp_fuse_array_chk #(
   parameter int unsigned IDX_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pg_valid,
   input logic             pg_ready,
   input logic             pg_ack,
   input logic             pg_nak,
   input logic             prot_hit,
   input logic [IDX_W-1:0] rd_bit_idx,
   input logic             rd_bit,
   input logic             dbg_en,
   input logic             chk_busy,
   input logic             chk_done
);
   AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pg_ack && pg_nak)); // R5
   AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_ack || pg_nak) |-> $past(pg_valid && pg_ready)); // R5
   AST_READY_LOW_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      chk_busy |-> !pg_ready); // R5
   AST_PROT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_valid && pg_ready && prot_hit) |=> pg_nak); // R3
   AST_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_bit) && rd_bit_idx == $past(rd_bit_idx) && !$past(dbg_en)) |-> rd_bit); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |=> !chk_done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |-> !chk_busy); // R9
endmodule

bind otp_fuse_array otp_fuse_array_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pg_valid  (pg_valid),
   .pg_ready  (pg_ready),
   .pg_ack    (pg_ack),
   .pg_nak    (pg_nak),
   .prot_hit  (prot_hit),
   .rd_bit_idx(rd_bit_idx),
   .rd_bit    (rd_bit),
   .dbg_en    (dbg_en),
   .chk_busy  (chk_busy),
   .chk_done  (chk_done)
);

// File: tb/tb_otp_fuse_array.sv
module tb_otp_fuse_array;
   localparam int CLK_PERIOD = 10;
   localparam int NB     = 3;
   localparam int BROWS  = 64;
   localparam int NROWS  = NB * BROWS;
   localparam int NBITS  = NROWS * 32;
   localparam int RAW    = 8;
   localparam int IW     = 13;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pg_valid = 1'b0;
   logic [IW-1:0]   pg_idx = '0;
   logic            pg_ready, pg_ack, pg_nak;
   logic [RAW-1:0]  rd_row = '0;
   logic [31:0]     rd_row_data;
   logic [IW-1:0]   rd_bit_idx = '0;
   logic            rd_bit;
   logic            chk_start = 1'b0;
   logic            chk_autofill = 1'b0;
   logic            chk_busy, chk_done;
   logic [NB-1:0]   chk_pass;
   logic            dbg_en = 1'b0;
   logic [RAW-1:0]  dbg_row = '0;
   logic [31:0]     dbg_data = '0;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [NROWS];

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_fuse_array dut (
      .clk(clk), .rst_n(rst_n),
      .pg_valid(pg_valid), .pg_idx(pg_idx), .pg_ready(pg_ready),
      .pg_ack(pg_ack), .pg_nak(pg_nak),
      .rd_row(rd_row), .rd_row_data(rd_row_data),
      .rd_bit_idx(rd_bit_idx), .rd_bit(rd_bit),
      .chk_start(chk_start), .chk_autofill(chk_autofill),
      .chk_busy(chk_busy), .chk_done(chk_done), .chk_pass(chk_pass),
      .dbg_en(dbg_en), .dbg_row(dbg_row), .dbg_data(dbg_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Protected: indices 5, 100, 6143 (2079 is in the table but not valid)
   function automatic bit exp_reject(input int idx);
      return (idx >= NBITS) || idx == 5 || idx == 100 || idx == 6143;
   endfunction

   function automatic logic [NB-1:0] exp_pass(input bit fill);
      logic [NB-1:0] v = '0;
      for (int b = 0; b < NB; b++) begin
         logic [3:0] f = model[b*BROWS][31:28];
         v[b] = (f == 4'b1010) || (fill && f == 4'b0000);
      end
      return v;
   endfunction

   task automatic check_row(input int r, input string req);
      rd_row = RAW'(r);
      #1;
      check(rd_row_data === model[r], req, rd_row_data, model[r]);
   endtask

   task automatic prog(input int idx, input string req);
      bit rej = exp_reject(idx);
      @(negedge clk);
      pg_valid = 1'b1;
      pg_idx   = IW'(idx);
      @(negedge clk);
      pg_valid = 1'b0;
      check(pg_ack === !rej && pg_nak === rej, req, {30'd0, pg_ack, pg_nak},
            {30'd0, !rej, rej});
      if (!rej) model[idx/32][idx%32] = 1'b1;
      if (idx < NBITS) begin
         rd_bit_idx = IW'(idx);
         #1;
         check(rd_bit === model[idx/32][idx%32], req, 32'(rd_bit),
               32'(model[idx/32][idx%32]));
         check_row(idx/32, req);
      end
   endtask

   task automatic dbg_write(input int r, input logic [31:0] d, input bit en);
      @(negedge clk);
      dbg_en = en; dbg_row = RAW'(r); dbg_data = d;
      @(negedge clk);
      dbg_en = 1'b0;
      if (en) model[r] = d;
   endtask

   task automatic scan(input bit fill, input string tag);
      logic [NB-1:0] exp = exp_pass(fill);
      int cnt = 0;
      @(negedge clk);
      chk_start = 1'b1; chk_autofill = fill;
      @(negedge clk);
      chk_start = 1'b0;
      check(chk_busy === 1'b1 && pg_ready === 1'b0, {"R5 ", tag},
            {30'd0, chk_busy, pg_ready}, 32'h2);
      while (!chk_done && cnt < 20) begin
         @(negedge clk);
         cnt++;
      end
      check(cnt == NB, {"R9 ", tag}, cnt, NB);
      check(chk_pass === exp, {"R7 R9 ", tag}, 32'(chk_pass), 32'(exp));
      for (int b = 0; b < NB; b++)
         if (fill && model[b*BROWS][31:28] == 4'b0000) model[b*BROWS][31:28] = 4'b1010;
      for (int b = 0; b < NB; b++) check_row(b*BROWS, {"R8 ", tag});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0f0e));
      for (int r = 0; r < NROWS; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      check(pg_ready === 1'b1 && pg_ack === 1'b0 && pg_nak === 1'b0 &&
            chk_busy === 1'b0 && chk_done === 1'b0, "R6",
            {27'd0, pg_ready, pg_ack, pg_nak, chk_busy, chk_done}, 32'h10);
      check_row(0, "R6"); check_row(100, "R6"); check_row(NROWS-1, "R6");

      // R1 directed program, R2 repeat programming
      prog(37, "R1");
      prog(37, "R2");
      prog(38, "R2");
      // R3 protected and masked-off entries
      prog(5, "R3");
      prog(100, "R3");
      prog(6143, "R3");
      prog(2079, "R3 invalid entry");
      prog(6142, "R1 last row");
      // R4 out of range
      prog(NBITS, "R4");
      prog(8191, "R4");
      check_row(0, "R3"); check_row(3, "R3");

      // R1 R2 random programming with protected and out-of-range mix
      for (int n = 0; n < 400; n++) begin
         int sel = $urandom_range(0, 19);
         int idx;
         if (sel == 0) idx = 5;
         else if (sel == 1) idx = 100;
         else if (sel == 2) idx = $urandom_range(NBITS, 8191);
         else idx = $urandom_range(0, NBITS-1);
         prog(idx, "R1 R2 random");
      end
      for (int r = 0; r < NROWS; r += 7) check_row(r, "R2 sweep");

      // R10 debug port
      dbg_write(10, 32'hDEAD_BEEF, 1'b0);
      check_row(10, "R10 disabled");
      dbg_write(10, 32'h1234_5678, 1'b1);
      check_row(10, "R10 enabled");

      // R7 R8 R9 marker scans
      dbg_write(0,   32'hA000_1234, 1'b1);
      dbg_write(64,  32'h0000_0055, 1'b1);
      dbg_write(128, 32'h5000_0000, 1'b1);
      scan(1'b0, "blank no fill");
      scan(1'b1, "fill blank only");
      dbg_write(0,   32'h3000_0001, 1'b1);
      dbg_write(64,  32'h1000_0000, 1'b1);
      dbg_write(128, 32'hA0F0_0000, 1'b1);
      scan(1'b0, "top bank only");
      dbg_write(0,   32'h0000_00FF, 1'b1);
      dbg_write(64,  32'h0000_0000, 1'b1);
      dbg_write(128, 32'hB000_0000, 1'b1);
      scan(1'b1, "two blanks");
      prog(200, "R5 after scan");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule